// File: doc/BRIEF.md
# Time-of-Day Target Compare Unit

This block keeps a free-running 64-bit time counter and a 64-bit target time. In every clock cycle the counter advances by a programmable step. When the counter exactly equals the target, a compare event fires. The event does four things: it raises a one-cycle pulse, it can drive an output pin, and it sets a sticky interrupt status bit. It also moves the target to its next value.

The target moves in one of two ways, chosen by a mode bit:
- **Load mode:** the new target is taken from a 64-bit reload register. Software uses this to arm the next trigger time in advance.
- **Add mode:** the reload value is added to the current target. This gives a periodic event that wraps cleanly past zero.

A host reaches the three 64-bit registers (counter, target, reload) and two control words through a 32-bit write port. A 64-bit register takes its new value only once both of its halves have arrived. Two external inputs can clear the interrupt status. Each passes through a synchroniser and a glitch filter. Its filtered rising edge clears the status bit when that input is enabled as a clear source.

The write port uses valid/ready. `wr_ready` is held high, so a beat is taken in every cycle in which `wr_valid` is high, and the host never sees back-pressure. All other pins are plain levels or pulses.

Top module: `ptp_target_cmp`

## Requirements
- R1: `wr_ready` is always 1, and a write is taken on each rising clock edge with `wr_valid` high. `wr_addr` selects the register:
  - 0/1: counter low/high half.
  - 2/3: target low/high half.
  - 4/5: reload low/high half.
  - 6: control word.
  - 7: status.
- R2: A 64-bit register keeps its old value while only one half has been written. Once the second half has arrived, in either order, the full value appears in the cycle after that second write, not in the cycle of it. Writing the same half again just replaces the pending half.
- R3: In each cycle without a host commit, the counter advances by the control step field, modulo 2^64. A committed host write replaces the counter value.
- R4: A compare event occurs in a cycle where the counter equals the target on all 64 bits. `evt_pulse` is high for exactly the cycle after each event. A host write that makes the counter equal to the target also causes an event.
- R5: With control bit 0 = 1 (load mode), an event loads the target from the reload register.
- R6: With control bit 0 = 0 (add mode), an event adds the reload value to the target, modulo 2^64. If a host target commit falls in the same cycle as an event, the commit wins.
- R7: An event sets `int_sts`. `irq` equals `int_sts` AND control bit 1.
- R8: Writing status with bit 0 = 1 clears `int_sts`. If an event falls in the same cycle as a clear, the status stays set.
- R9: External input i is a clear source when control bit 2+i is set. Its rising edge clears `int_sts` once the synchronised level has been high on two consecutive clock samples. A pulse of one clock period, or any edge on an input that is not enabled, leaves `int_sts` unchanged.
- R10: `evt_pin` equals `evt_pulse` when control bit 4 is set, and is 0 otherwise. Control bits 12:5 hold the counter step.
- R11: Reset values:
  - counter 0;
  - target all ones;
  - reload 0;
  - step 1, with all other control bits 0;
  - `int_sts`, `irq`, `evt_pulse` and `evt_pin` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Host write accepted (held high) |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| ext_in | input | 2 | External interrupt-clear inputs, asynchronous |
| irq | output | 1 | Masked timer interrupt |
| evt_pulse | output | 1 | One-cycle compare event pulse |
| evt_pin | output | 1 | Event pulse gated by pin enable |
| int_sts | output | 1 | Timer interrupt status |
| clk_now | output | 64 | Current counter value |
| tgt_now | output | 64 | Current target value |

## Verification
The cycle-level assertions check the local rules in every cycle:
- the counter advances by the step unless a commit arrives;
- the target holds unless a commit or an event moves it;
- each event is followed by a pulse and a set status bit;
- `irq` and `evt_pin` are never high without their source.

Only the bench scenarios can show the behaviour that spans several writes or cycles:
- the two-half commit in both orders;
- the exact event latency after a counter write;
- periodic spacing at step 1 and step 3, including wrap past zero;
- set-over-clear priority;
- the filter's rejection of a one-cycle pulse on an external input.

// File: rtl/ptp_cmp_pkg.sv
package ptp_cmp_pkg;
  localparam int HALF_W    = 32;
  localparam int STEP_W    = 8;
  localparam int N_CLR_SRC = 2;

  typedef enum logic [2:0] {
    A_CLK_LO = 3'd0, A_CLK_HI = 3'd1,
    A_TGT_LO = 3'd2, A_TGT_HI = 3'd3,
    A_RLD_LO = 3'd4, A_RLD_HI = 3'd5,
    A_CTRL   = 3'd6, A_STAT   = 3'd7
  } reg_addr_e;

  // Control word, LSB first: load mode, irq enable, clear enables, pin enable, step.
  typedef struct packed {
    logic [STEP_W-1:0]    step;
    logic                 out_en;
    logic [N_CLR_SRC-1:0] clr_en;
    logic                 irq_en;
    logic                 load_mode;
  } ctrl_t;
endpackage

// File: rtl/ptp_split_reg.sv
// Collects a wide value from two half-width writes and commits it one cycle
// after the second half lands, in either order.
module ptp_split_reg #(
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HW-1:0]   wdata,
  output logic            commit,
  output logic [2*HW-1:0] value
);
  logic [HW-1:0] sh_lo, sh_hi;
  logic [1:0]    pend, pend_nx;

  assign pend_nx = pend | {wr_hi, wr_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_lo  <= '0;
      sh_hi  <= '0;
      pend   <= '0;
      commit <= 1'b0;
      value  <= '0;
    end else begin
      commit <= 1'b0;
      if (wr_lo) sh_lo <= wdata;
      if (wr_hi) sh_hi <= wdata;
      if ((wr_lo || wr_hi) && (&pend_nx)) begin
        commit <= 1'b1;
        value  <= {(wr_hi ? wdata : sh_hi), (wr_lo ? wdata : sh_lo)};
        pend   <= '0;
      end else begin
        pend <= pend_nx;
      end
    end
  end
endmodule

// File: rtl/ptp_glitch_filter.sv
// Synchronises an asynchronous input and reports a rising edge only after
// the synchronised level has held for LEN consecutive samples.
module ptp_glitch_filter #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int CW = $clog2(LEN + 1);

  logic          s1, s2, lvl;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      lvl  <= 1'b0;
      cnt  <= '0;
      rise <= 1'b0;
    end else begin
      s1   <= din;
      s2   <= s1;
      rise <= 1'b0;
      if (s2 != lvl) begin
        if (cnt == CW'(LEN - 1)) begin
          lvl  <= s2;
          cnt  <= '0;
          rise <= s2;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ptp_target_cmp.sv
module ptp_target_cmp
  import ptp_cmp_pkg::*;
#(
  parameter int TW       = 2 * HALF_W,
  parameter int AW       = 3,
  parameter int FILT_LEN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [AW-1:0]        wr_addr,
  input  logic [TW/2-1:0]      wr_data,
  input  logic [N_CLR_SRC-1:0] ext_in,
  output logic                 irq,
  output logic                 evt_pulse,
  output logic                 evt_pin,
  output logic                 int_sts,
  output logic [TW-1:0]        clk_now,
  output logic [TW-1:0]        tgt_now
);
  localparam int HW     = TW / 2;
  localparam int NWIDE  = 3;            // 0: counter, 1: target, 2: reload
  localparam int CTRL_W = $bits(ctrl_t);

  logic [NWIDE-1:0]     commit_v;
  logic [TW-1:0]        cval [NWIDE];
  logic [N_CLR_SRC-1:0] ext_rise;
  ctrl_t                ctrl_q;
  logic [TW-1:0]        clk_q, tgt_q, rld_q;
  logic                 hit, evt_q, sts_q, stat_clr, ext_clr;
  logic [STEP_W-1:0]    step_w;
  logic                 mode_w;

  assign wr_ready = 1'b1;

  for (genvar g = 0; g < NWIDE; g++) begin : g_wide
    ptp_split_reg #(.HW(HW)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (wr_valid && (wr_addr == AW'(2 * g))),
      .wr_hi  (wr_valid && (wr_addr == AW'(2 * g + 1))),
      .wdata  (wr_data),
      .commit (commit_v[g]),
      .value  (cval[g])
    );
  end

  for (genvar i = 0; i < N_CLR_SRC; i++) begin : g_filt
    ptp_glitch_filter #(.LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ext_in[i]),
      .rise  (ext_rise[i])
    );
  end

  assign step_w   = ctrl_q.step;
  assign mode_w   = ctrl_q.load_mode;
  assign hit      = (clk_q == tgt_q);
  assign stat_clr = wr_valid && (wr_addr == AW'(A_STAT)) && wr_data[0];
  assign ext_clr  = |(ext_rise & ctrl_q.clr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      ctrl_q.step <= STEP_W'(1);
    end else if (wr_valid && (wr_addr == AW'(A_CTRL))) begin
      ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      tgt_q <= '1;
      rld_q <= '0;
      evt_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      clk_q <= commit_v[0] ? cval[0] : clk_q + TW'(step_w);
      if (commit_v[1])  tgt_q <= cval[1];
      else if (hit)     tgt_q <= mode_w ? rld_q : tgt_q + rld_q;
      if (commit_v[2])  rld_q <= cval[2];
      evt_q <= hit;
      if (hit)                       sts_q <= 1'b1;
      else if (stat_clr || ext_clr)  sts_q <= 1'b0;
    end
  end

  assign int_sts   = sts_q;
  assign irq       = sts_q & ctrl_q.irq_en;
  assign evt_pulse = evt_q;
  assign evt_pin   = evt_q & ctrl_q.out_en;
  assign clk_now   = clk_q;
  assign tgt_now   = tgt_q;
endmodule

// File: rtl/ptp_target_cmp_chk.sv
module ptp_target_cmp_chk #(
  parameter int TW     = 64,
  parameter int STEP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TW-1:0]     clk_now,
  input logic [TW-1:0]     tgt_now,
  input logic [TW-1:0]     rld_q,
  input logic [STEP_W-1:0] step,
  input logic              load_mode,
  input logic              hit,
  input logic              clk_commit,
  input logic              tgt_commit,
  input logic              evt_pulse,
  input logic              evt_pin,
  input logic              int_sts,
  input logic              irq
);
  p_clock_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_commit |=> clk_now == $past(clk_now) + TW'($past(step)));

  p_target_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !tgt_commit) |=> $stable(tgt_now));

  p_event_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> evt_pulse);

  p_load_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && load_mode && !tgt_commit) |=> tgt_now == $past(rld_q));

  p_add_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load_mode && !tgt_commit) |=> tgt_now == $past(tgt_now) + $past(rld_q));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> int_sts);

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_sts);

  p_pin_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pin |-> evt_pulse);
endmodule

bind ptp_target_cmp ptp_target_cmp_chk #(.TW(TW), .STEP_W(ptp_cmp_pkg::STEP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_now    (clk_now),
  .tgt_now    (tgt_now),
  .rld_q      (rld_q),
  .step       (step_w),
  .load_mode  (mode_w),
  .hit        (hit),
  .clk_commit (commit_v[0]),
  .tgt_commit (commit_v[1]),
  .evt_pulse  (evt_pulse),
  .evt_pin    (evt_pin),
  .int_sts    (int_sts),
  .irq        (irq)
);

// File: tb/sim_ptp_target_cmp.sv
module sim_ptp_target_cmp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  ext_in = '0;
  logic        irq, evt_pulse, evt_pin, int_sts;
  logic [63:0] clk_now, tgt_now;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_target_cmp u0 (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_addr, .wr_data, .ext_in,
    .irq, .evt_pulse, .evt_pin, .int_sts, .clk_now, .tgt_now
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [7:0] step, input logic oe,
                                     input logic [1:0] ce, input logic ie, input logic md);
    return {19'd0, step, oe, ce, ie, md};
  endfunction

  function automatic logic [63:0] next_tgt(input logic md, input logic [63:0] t, input logic [63:0] r);
    return md ? r : t + r;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wr64(input logic [2:0] base, input logic [63:0] v, input bit hi_first);
    if (hi_first) begin wr(base + 3'd1, v[63:32]); wr(base, v[31:0]); end
    else          begin wr(base, v[31:0]); wr(base + 3'd1, v[63:32]); end
  endtask

  task automatic wait_evt(input int maxc, output int d);
    d = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (evt_pulse) begin d = i; break; end
    end
  endtask

  task automatic ext_pulse(input int idx, input int len);
    @(negedge clk);
    ext_in[idx] = 1'b1;
    repeat (len) @(negedge clk);
    ext_in[idx] = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int d;
    logic [63:0] x, t, r;
    void'($urandom(32'd7311));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 target", tgt_now, '1);
    chk("R11 counter", clk_now, 64'd0);
    chk("R11 status", int_sts, 0);
    chk("R11 irq", irq, 0);
    chk("R11 pulse", evt_pulse, 0);
    chk("R1 ready", wr_ready, 1);
    @(negedge clk);
    chk("R3 default step", clk_now, 64'd1);

    // R2 lone half, then second half; commit one cycle later
    wr(3'd2, 32'h1357_9bdf);
    repeat (3) @(negedge clk);
    chk("R2 lone half", tgt_now, '1);
    wr(3'd3, 32'hcafe_0001);
    chk("R2 not same cycle", tgt_now, '1);
    @(negedge clk);
    chk("R2 commit", tgt_now, 64'hcafe_0001_1357_9bdf);

    // R3 counter wrap, written high half first
    wr64(3'd0, 64'hffff_ffff_ffff_fffd, 1'b1);
    @(negedge clk);
    chk("R3 counter load", clk_now, 64'hffff_ffff_ffff_fffd);
    repeat (5) @(negedge clk);
    chk("R3 counter wrap", clk_now, 64'd2);

    // R5 load mode
    wr(3'd6, cw(8'd1, 0, 2'b00, 0, 1));
    r = 64'h0f0f_0f0f_0f0f_0f0f;
    t = 64'h4000_0000_0000_0100;
    wr64(3'd4, r, 1'b0);
    wr64(3'd2, t, 1'b1);
    wr64(3'd0, t - 64'd5, 1'b0);
    wait_evt(30, d);
    chk("R4 event latency", d, 7);
    chk("R5 loaded target", tgt_now, r);
    chk("R7 status set", int_sts, 1);
    @(negedge clk);
    chk("R4 single pulse", evt_pulse, 0);

    // R6 add mode with wrap past zero
    wr(3'd6, cw(8'd1, 0, 2'b00, 0, 0));
    wr64(3'd4, 64'd7, 1'b0);
    wr64(3'd2, 64'hffff_ffff_ffff_fff6, 1'b0);
    wr64(3'd0, 64'hffff_ffff_ffff_fff4, 1'b0);
    wait_evt(30, d);
    chk("R4 add latency", d, 4);
    chk("R6 first add", tgt_now, 64'hffff_ffff_ffff_fffd);
    wait_evt(30, d);
    chk("R6 period", d, 7);
    chk("R6 wrapped target", tgt_now, 64'd4);

    // R10 step 3, period 9 -> every 3 cycles
    wr(3'd6, cw(8'd3, 0, 2'b00, 0, 0));
    t = 64'h7000_0000_0000_0000;
    wr64(3'd4, 64'd9, 1'b0);
    wr64(3'd2, t, 1'b0);
    wr64(3'd0, t - 64'd6, 1'b0);
    wait_evt(30, d);
    chk("R10 step latency", d, 4);
    wait_evt(30, d);
    chk("R10 step spacing", d, 3);
    chk("R6 step target", tgt_now, t + 64'd18);

    // Counter frozen on target: event every cycle (R4 host write triggers)
    x = 64'h1234_5678_9abc_def0;
    wr(3'd6, cw(8'd0, 0, 2'b00, 0, 0));
    wr64(3'd4, 64'd0, 1'b0);
    wr64(3'd2, x, 1'b0);
    wr64(3'd0, x, 1'b0);
    repeat (3) @(negedge clk);
    chk("R4 write-caused event", evt_pulse, 1);
    chk("R10 pin disabled", evt_pin, 0);
    wr(3'd6, cw(8'd0, 1, 2'b00, 0, 0));
    chk("R10 pin enabled", evt_pin, 1);
    wr(3'd7, 32'd1);
    chk("R8 set wins", int_sts, 1);

    // Stop events: add 1 moves target off the frozen counter
    wr64(3'd4, 64'd1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R4 events stop", evt_pulse, 0);
    chk("R6 add one", tgt_now, x + 64'd1);
    chk("R7 status held", int_sts, 1);
    chk("R7 irq masked", irq, 0);
    wr(3'd6, cw(8'd0, 0, 2'b00, 1, 0));
    chk("R7 irq enabled", irq, 1);

    // R9 external clears
    ext_pulse(1, 5);
    repeat (8) @(negedge clk);
    chk("R9 disabled source", int_sts, 1);
    wr(3'd6, cw(8'd0, 0, 2'b01, 1, 0));
    ext_pulse(0, 1);
    repeat (8) @(negedge clk);
    chk("R9 short pulse ignored", int_sts, 1);
    ext_pulse(0, 4);
    repeat (8) @(negedge clk);
    chk("R9 ext0 clear", int_sts, 0);
    chk("R7 irq follows", irq, 0);

    wr64(3'd0, x + 64'd1, 1'b0);
    wait_evt(10, d);
    chk("R4 rewrite latency", d, 2);
    @(negedge clk);
    chk("R7 set again", int_sts, 1);
    wr(3'd7, 32'd1);
    chk("R8 w1c", int_sts, 0);

    wr64(3'd0, x + 64'd2, 1'b1);
    wait_evt(10, d);
    @(negedge clk);
    wr(3'd6, cw(8'd0, 0, 2'b10, 1, 0));
    ext_pulse(1, 4);
    repeat (8) @(negedge clk);
    chk("R9 ext1 clear", int_sts, 0);

    // Random first-event checks, both modes
    for (int it = 0; it < 24; it++) begin
      logic md;
      int g;
      md = 1'($urandom % 2);
      g  = int'($urandom % 20);
      t  = {$urandom, $urandom};
      r  = md ? {$urandom, $urandom} : 64'(16 + $urandom % 64);
      wr(3'd6, cw(8'd1, 0, 2'b00, 0, md));
      wr64(3'd4, r, 1'($urandom % 2));
      wr64(3'd2, t, 1'($urandom % 2));
      wr64(3'd0, t - 64'(g), 1'($urandom % 2));
      wait_evt(40, d);
      chk(md ? "R5 random latency" : "R6 random latency", d, g + 2);
      chk(md ? "R5 random target" : "R6 random target", tgt_now, next_tgt(md, t, r));
      chk("R7 random status", int_sts, 1);
    end

    finish_run();
  end
endmodule